// File: doc/BRIEF.md
# PAUSE Frame Timing Controller

This block is the MAC-side control for IEEE 802.3 PAUSE flow control. On the transmit side it follows a pause-request level from the switch. When the request rises it asks the frame generator for a PAUSE frame carrying a programmed quanta value. It then runs a local countdown that mirrors the peer's pause timer. When that countdown falls to a programmed refresh threshold and the request is still present, it asks for another PAUSE with the full quanta. When the request drops, it sends one PAUSE with quanta zero to release the peer.

On the receive side, a received PAUSE loads a pause timer with its quanta. While that timer is non-zero, the block holds back data transmission. The hold only changes between frames, and PAUSE frames are never held back. Both timers count down on a strobe that marks one quantum (512 bit times) at the current link speed. A configuration bit can make received PAUSE frames ignored. Half duplex forces both directions of PAUSE handling off.

Top module: `pause_ctrl`

## Requirements
- R1: The transmitted quanta register (cfg_sel_i = 0) resets to 0xFFFF and takes cfg_wdata_i on a cycle with cfg_wr_i high.
- R2: The refresh threshold register (cfg_sel_i = 1) resets to 0xFF00 and takes cfg_wdata_i on a cycle with cfg_wr_i high.
- R3: A rise of pause_req_i in full duplex raises pause_send_o with pause_quanta_o equal to the programmed quanta. Both hold steady until the cycle in which pause_ack_i is high.
- R4: On acceptance of a non-zero PAUSE, the transmit countdown loads that quanta and decrements once per quantum_tick_i. Once it is at or below the threshold and the request still holds, another PAUSE with the full programmed quanta is requested.
- R5: If pause_req_i drops while the countdown runs, exactly one PAUSE with quanta zero is requested, and no further PAUSE follows it.
- R6: A received PAUSE (rx_pause_valid_i) loads the receive timer with rx_pause_quanta_i. This also happens while the timer is already running, and a quanta of zero clears the timer at once.
- R7: The receive timer decrements once per quantum_tick_i down to zero. tx_hold_o reports a non-zero timer.
- R8: With rx_pause_ign_i high, the receive timer is held at zero and received PAUSE frames do not change tx_hold_o.
- R9: With full_duplex_i low, pause_send_o stays low and received PAUSE frames do not raise tx_hold_o.
- R10: tx_hold_o changes only on clock edges where tx_busy_i is low. It follows the receive timer state one cycle later.
- R11: PAUSE requests on pause_send_o proceed regardless of tx_hold_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| full_duplex_i | input | 1 | Link is in full duplex |
| rx_pause_ign_i | input | 1 | Ignore received PAUSE frames |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0: transmit quanta, 1: refresh threshold |
| cfg_wdata_i | input | 16 | Configuration write data |
| quantum_tick_i | input | 1 | One-cycle strobe per 512 bit times |
| pause_req_i | input | 1 | Pause request level from the switch |
| pause_send_o | output | 1 | Request to send a PAUSE frame |
| pause_quanta_o | output | 16 | Quanta for the requested PAUSE frame |
| pause_ack_i | input | 1 | Frame generator accepts the PAUSE request |
| rx_pause_valid_i | input | 1 | A PAUSE frame was received |
| rx_pause_quanta_i | input | 16 | Quanta of the received PAUSE frame |
| tx_busy_i | input | 1 | A data frame is being transmitted |
| tx_hold_o | output | 1 | Hold further data frames |

## Verification
The hardest case to reach is the refresh. It needs the transmit countdown to fall from the quanta to the threshold while the request stays high. With the reset values, that gap is 255 quantum strobes. The bench first runs that full default gap, then writes a short quanta and threshold to exercise the refresh and the release frame quickly. The case where a PAUSE is received while a data frame is in flight is reached by holding tx_busy_i high across the load and the clear of the receive timer.

// File: rtl/pause_pkg.sv
package pause_pkg;
  parameter int unsigned QUANTA_W = 16;
  localparam logic [QUANTA_W-1:0] DEF_QUANTA = 16'hFFFF;
  localparam logic [QUANTA_W-1:0] DEF_THRESH = 16'hFF00;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_RUN  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/pause_cfg.sv
module pause_cfg #(
  parameter int unsigned QW = pause_pkg::QUANTA_W,
  parameter logic [QW-1:0] DEF_Q = pause_pkg::DEF_QUANTA,
  parameter logic [QW-1:0] DEF_T = pause_pkg::DEF_THRESH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          sel_i,
  input  logic [QW-1:0] wdata_i,
  output logic [QW-1:0] quanta_o,
  output logic [QW-1:0] thresh_o
);
  logic [QW-1:0] quanta_q, thresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quanta_q <= DEF_Q;
      thresh_q <= DEF_T;
    end else if (wr_i) begin
      if (sel_i) thresh_q <= wdata_i;
      else       quanta_q <= wdata_i;
    end
  end

  assign quanta_o = quanta_q;
  assign thresh_o = thresh_q;

  // R1
  quanta_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sel_i) |=> quanta_q == $past(wdata_i));
  // R2
  thresh_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i) |=> thresh_q == $past(wdata_i));
endmodule

// File: rtl/pause_tx_timer.sv
module pause_tx_timer
  import pause_pkg::*;
#(
  parameter int unsigned QW = QUANTA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          full_duplex_i,
  input  logic          req_i,
  input  logic          tick_i,
  input  logic [QW-1:0] quanta_i,
  input  logic [QW-1:0] thresh_i,
  input  logic          ack_i,
  output logic          send_o,
  output logic [QW-1:0] send_quanta_o
);
  tx_state_e     state_q, state_d;
  logic [QW-1:0] cnt_q, cnt_d;
  logic [QW-1:0] sq_q, sq_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sq_d    = sq_q;
    if (!full_duplex_i) begin
      state_d = TX_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (req_i) begin
          state_d = TX_SEND;
          sq_d    = quanta_i;
        end
        TX_SEND: if (ack_i) begin
          if (sq_q == '0) begin
            state_d = TX_IDLE;
            cnt_d   = '0;
          end else begin
            state_d = TX_RUN;
            cnt_d   = sq_q;
          end
        end
        TX_RUN: begin
          if (!req_i) begin
            state_d = TX_SEND;            // release the peer
            sq_d    = '0;
          end else if (cnt_q <= thresh_i) begin
            state_d = TX_SEND;            // refresh with full quanta
            sq_d    = quanta_i;
          end else if (tick_i) begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: state_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      sq_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sq_q    <= sq_d;
    end
  end

  assign send_o        = (state_q == TX_SEND);
  assign send_quanta_o = sq_q;

  // R3
  send_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_o && !ack_i && full_duplex_i) |=> (send_o && $stable(send_quanta_o)));
  // R4
  tick_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_RUN && full_duplex_i && req_i && tick_i && cnt_q > thresh_i)
      |=> cnt_q == $past(cnt_q) - 1'b1);
  // R5
  release_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_o && ack_i && send_quanta_o == '0) |=> !send_o);
  // R9
  half_duplex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_duplex_i |=> !send_o);
endmodule

// File: rtl/pause_rx_timer.sv
module pause_rx_timer #(
  parameter int unsigned QW = pause_pkg::QUANTA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          valid_i,
  input  logic [QW-1:0] quanta_i,
  input  logic          tick_i,
  output logic          active_o
);
  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!enable_i)        cnt_q <= '0;
    else if (valid_i)          cnt_q <= quanta_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  // R6
  rx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && valid_i) |=> cnt_q == $past(quanta_i));
  // R8
  rx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> cnt_q == '0);
  // R7
  rx_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !valid_i) |=> cnt_q == '0);
endmodule

// File: rtl/pause_tx_gate.sv
module pause_tx_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic pause_active_i,
  output logic hold_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= 1'b0;
    else if (!busy_i) hold_q <= pause_active_i;
  end

  assign hold_o = hold_q;

  // R10
  gate_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(hold_o));
endmodule

// File: rtl/pause_ctrl.sv
module pause_ctrl
  import pause_pkg::*;
#(
  parameter int unsigned QW = QUANTA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          full_duplex_i,
  input  logic          rx_pause_ign_i,
  input  logic          cfg_wr_i,
  input  logic          cfg_sel_i,
  input  logic [QW-1:0] cfg_wdata_i,
  input  logic          quantum_tick_i,
  input  logic          pause_req_i,
  output logic          pause_send_o,
  output logic [QW-1:0] pause_quanta_o,
  input  logic          pause_ack_i,
  input  logic          rx_pause_valid_i,
  input  logic [QW-1:0] rx_pause_quanta_i,
  input  logic          tx_busy_i,
  output logic          tx_hold_o
);
  logic [QW-1:0] cfg_quanta, cfg_thresh;
  logic          rx_active;
  logic          rx_enable;

  assign rx_enable = full_duplex_i && !rx_pause_ign_i;

  pause_cfg #(.QW(QW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cfg_wr_i),
    .sel_i    (cfg_sel_i),
    .wdata_i  (cfg_wdata_i),
    .quanta_o (cfg_quanta),
    .thresh_o (cfg_thresh)
  );

  pause_tx_timer #(.QW(QW)) u_tx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .full_duplex_i (full_duplex_i),
    .req_i         (pause_req_i),
    .tick_i        (quantum_tick_i),
    .quanta_i      (cfg_quanta),
    .thresh_i      (cfg_thresh),
    .ack_i         (pause_ack_i),
    .send_o        (pause_send_o),
    .send_quanta_o (pause_quanta_o)
  );

  pause_rx_timer #(.QW(QW)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (rx_enable),
    .valid_i  (rx_pause_valid_i),
    .quanta_i (rx_pause_quanta_i),
    .tick_i   (quantum_tick_i),
    .active_o (rx_active)
  );

  pause_tx_gate u_gate (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .busy_i         (tx_busy_i),
    .pause_active_i (rx_active),
    .hold_o         (tx_hold_o)
  );

  // R11
  no_send_gating_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_hold_o && full_duplex_i && pause_req_i && !pause_send_o && $past(!pause_req_i))
      |=> pause_send_o);
endmodule

// File: tb/pause_ctrl_tb_top.sv
module pause_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fd = 1'b1, ign = 1'b0, cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        tick = 1'b0, req = 1'b0, ack = 1'b0;
  logic        send;
  logic [15:0] squanta;
  logic        rxv = 1'b0;
  logic [15:0] rxq = '0;
  logic        busy = 1'b0, hold;

  int checks = 0, failures = 0, frames_seen = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  pause_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .full_duplex_i(fd), .rx_pause_ign_i(ign),
    .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .quantum_tick_i(tick), .pause_req_i(req), .pause_send_o(send),
    .pause_quanta_o(squanta), .pause_ack_i(ack), .rx_pause_valid_i(rxv),
    .rx_pause_quanta_i(rxq), .tx_busy_i(busy), .tx_hold_o(hold)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // frame generator model + scoreboard monitor
  always @(negedge clk) begin
    if (send && !ack) begin
      ack <= 1'b1;
      frames_seen++;
      if (exp_q.size() == 0) chk("R3 unexpected PAUSE", {16'h0, squanta}, 32'hDEAD);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {16'h0, squanta}, {16'h0, e});
      end
    end else ack <= 1'b0;
  end

  task automatic expect_frame(input logic [15:0] q, input string t);
    exp_q.push_back(q);
    tag_q.push_back(t);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic cfg(input logic s, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rx_pause(input logic [15:0] q);
    @(negedge clk);
    rxv = 1'b1; rxq = q;
    @(negedge clk);
    rxv = 1'b0;
  endtask

  task automatic drained(input string t);
    cyc(6);
    chk(t, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk("R3 reset send", send, 0);
    chk("R10 reset hold", hold, 0);

    // R1 default quanta, R4 refresh at default threshold after 255 ticks
    expect_frame(16'hFFFF, "R1 default quanta");
    req = 1'b1;
    cyc(6);
    ticks(254);
    cyc(4);
    chk("R2 no refresh above threshold", frames_seen, 1);
    expect_frame(16'hFFFF, "R2 refresh at default threshold");
    ticks(1);
    drained("R2 default refresh seen");
    expect_frame(16'h0000, "R5 release quanta zero");
    req = 1'b0;
    drained("R5 release seen");
    cyc(10);
    chk("R5 nothing after release", frames_seen, 3);

    // programmed quanta and threshold
    cfg(1'b0, 16'd20);
    cfg(1'b1, 16'd15);
    expect_frame(16'd20, "R1 programmed quanta");
    req = 1'b1;
    cyc(6);
    ticks(4);
    cyc(4);
    chk("R4 no early refresh", frames_seen, 4);
    expect_frame(16'd20, "R4 refresh full quanta");
    ticks(1);
    drained("R4 refresh seen");
    ticks(4);
    cyc(4);
    chk("R4 count restarted", frames_seen, 5);
    expect_frame(16'h0000, "R5 release after refresh");
    req = 1'b0;
    drained("R5 second release seen");
    cyc(10);
    chk("R5 single release", frames_seen, 6);

    // half duplex: no PAUSE sent, no honouring
    fd = 1'b0;
    req = 1'b1;
    cyc(20);
    chk("R9 no send in half duplex", frames_seen, 6);
    chk("R9 send low", send, 0);
    rx_pause(16'd10);
    cyc(3);
    chk("R9 rx ignored in half duplex", hold, 0);
    req = 1'b0;
    fd = 1'b1;
    cyc(3);

    // receive timer
    rx_pause(16'd3);
    cyc(1);
    chk("R7 hold after rx pause", hold, 1);
    ticks(2);
    cyc(2);
    chk("R7 still held", hold, 1);
    ticks(1);
    cyc(2);
    chk("R7 released at zero", hold, 0);

    rx_pause(16'd5);
    ticks(2);
    rx_pause(16'd5);
    ticks(4);
    cyc(2);
    chk("R6 reload extends pause", hold, 1);
    ticks(1);
    cyc(2);
    chk("R6 reload expires", hold, 0);

    rx_pause(16'd10);
    cyc(2);
    chk("R6 loaded", hold, 1);
    rx_pause(16'd0);
    cyc(2);
    chk("R6 zero quanta clears", hold, 0);

    // ignore bit
    ign = 1'b1;
    rx_pause(16'd10);
    cyc(3);
    chk("R8 ignored rx pause", hold, 0);
    ign = 1'b0;
    rx_pause(16'd10);
    cyc(2);
    chk("R8 honoured when enabled", hold, 1);
    ign = 1'b1;
    cyc(3);
    chk("R8 ignore clears pause", hold, 0);
    ign = 1'b0;

    // frame boundary gating
    busy = 1'b1;
    rx_pause(16'd5);
    cyc(3);
    chk("R10 no hold mid-frame", hold, 0);
    busy = 1'b0;
    cyc(2);
    chk("R10 hold at boundary", hold, 1);
    busy = 1'b1;
    rx_pause(16'd0);
    cyc(3);
    chk("R10 hold kept mid-frame", hold, 1);
    busy = 1'b0;
    cyc(2);
    chk("R10 hold dropped at boundary", hold, 0);

    // PAUSE bypasses the hold
    rx_pause(16'd100);
    cyc(2);
    chk("R11 hold active", hold, 1);
    expect_frame(16'd20, "R11 pause sent while held");
    req = 1'b1;
    drained("R11 frame seen while held");
    expect_frame(16'h0000, "R11 release while held");
    req = 1'b0;
    drained("R11 release seen");
    rx_pause(16'd0);
    cyc(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule